// File: doc/BRIEF.md
# Delay-Stretchable Launch Register

A bank of master-slave storage elements whose output update can be postponed by a second, offset test clock. A slow tester can then time a logic path between two registers: the launch of new data is moved later in the cycle, and the capture stays on the system clock edge. The path still has to settle inside the same margin, even though the clock runs well below its nominal rate. In normal operation the bank is an ordinary rising-edge register.

Every element is built from two level-sensitive latches. The master is transparent while the system clock is low and holds while it is high. The slave opens only while both the system clock and the effective test clock are high. Its closing control is the NAND of those two, and while closed it holds its value, so the output is always driven. With the test clock high the pair behaves as a plain flip-flop. With the test clock low at the system clock rise, the slave waits for the test clock to rise, so the launch delay equals the offset between the two edges.

The data bus is split into equal lanes, and a parameter mask selects which lanes see the test clock. The other lanes always launch on the system clock. With the default parameters the bus is 8 bits wide with two 4-bit lanes. Lane 0 (dataOut[3:0]) is delay-controlled and lane 1 (dataOut[7:4]) is plain.

Top module: `launch_delay_reg`

## Requirements
- R1: While rstN is low, every bit of dataOut is 0 at once, without waiting for a clock edge, and both latch stages are cleared.
- R2: With testMode low, every bit of dataOut takes the value dataIn had at the rising edge of sysClk and keeps it until the next rising edge, the same as a reference D flip-flop, cycle for cycle.
- R3: With testMode low, the level and edges of testClk have no effect on dataOut.
- R4: With testMode high, the delay-controlled bits (default dataOut[3:0]) keep their old value from the rising edge of sysClk until the next rising edge of testClk.
- R5: With testMode high, on the rising edge of testClk the delay-controlled bits take the value dataIn had at the preceding rising sysClk edge. The added launch delay therefore equals the offset between the two edges, for any offset that falls within the high phase of sysClk. In this mode testClk must be low at each sysClk rise and must rise once while sysClk is high.
- R6: The plain bits (default dataOut[7:4]) update on the rising edge of sysClk in both modes.
- R7: Changes of dataIn while sysClk is high never reach dataOut, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock; master transparent while low |
| testClk | input | 1 | Offset test clock; rising edge launches delay-controlled lanes in test mode |
| rstN | input | 1 | Asynchronous active-low clear of both latch stages |
| testMode | input | 1 | High selects delayed launch; low forces the effective test clock high |
| dataIn | input | WIDTH | Data to be stored |
| dataOut | output | WIDTH | Stored data, always driven |

## Verification
The hardest case to reach is the window between the sysClk rise and a later testClk rise. In that window the delay-controlled bits must still show the old word, the plain bits must already show the new word, and dataIn is already changing behind the closed master. The driver pulses testClk at 1, 2 or 3 ns into the high phase and flips dataIn 0.3 ns after every sysClk rise. The monitor then samples just before and just after each testClk edge. Normal-mode cycles with testClk toggling in the same pattern, a mid-run clear, and switches between modes complete the stimulus.

// File: rtl/ld_pkg.sv
package ld_pkg;
  // Latch-open strobes passed from the gate control to the latch bank.
  typedef struct packed {
    logic masterOpen;   // master latch transparent
    logic plainOpen;    // slave latch of a plain lane transparent
    logic delayedOpen;  // slave latch of a delay-controlled lane transparent
  } gate_strobes_t;
endpackage

// File: rtl/ld_gate_ctrl.sv
module ld_gate_ctrl
  import ld_pkg::*;
(
  input  logic          sysClk,
  input  logic          testClk,
  input  logic          testMode,
  output gate_strobes_t strobe
);
  logic effTestClk;
  logic slaveGateN;

  // Outside test mode the test clock is treated as held high.
  assign effTestClk = testClk | ~testMode;
  // Closing control of the delayed slave: NAND of both clocks.
  assign slaveGateN = ~(sysClk & effTestClk);

  always_comb begin
    strobe.masterOpen  = ~sysClk;
    strobe.plainOpen   = sysClk;
    strobe.delayedOpen = ~slaveGateN;
  end
endmodule

// File: rtl/ld_latch_bank.sv
module ld_latch_bank
  import ld_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int NUM_LANES = 2,
  parameter logic [NUM_LANES-1:0] LANE_MASK = 2'b01
) (
  input  logic             rstN,
  input  gate_strobes_t    strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);
  localparam int LANE_W = WIDTH / NUM_LANES;

  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    logic [LANE_W-1:0] masterVal;
    logic [LANE_W-1:0] slaveVal;
    logic              slaveOpen;

    if (LANE_MASK[lane]) begin : g_delayed
      assign slaveOpen = strobe.delayedOpen;
    end else begin : g_plain
      assign slaveOpen = strobe.plainOpen;
    end

    always_latch begin
      if (!rstN)                  masterVal = '0;
      else if (strobe.masterOpen) masterVal = dataIn[lane*LANE_W +: LANE_W];
    end

    // Closed slave keeps its value through its own feedback: output stays driven.
    always_latch begin
      if (!rstN)          slaveVal = '0;
      else if (slaveOpen) slaveVal = masterVal;
    end

    assign dataOut[lane*LANE_W +: LANE_W] = slaveVal;
  end
endmodule

// File: rtl/launch_delay_reg.sv
module launch_delay_reg
  import ld_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int NUM_LANES = 2,
  parameter logic [NUM_LANES-1:0] LANE_MASK = 2'b01
) (
  input  logic             sysClk,
  input  logic             testClk,
  input  logic             rstN,
  input  logic             testMode,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);
  gate_strobes_t strobe;

  ld_gate_ctrl i_ctrl (
    .sysClk  (sysClk),
    .testClk (testClk),
    .testMode(testMode),
    .strobe  (strobe)
  );

  ld_latch_bank #(
    .WIDTH    (WIDTH),
    .NUM_LANES(NUM_LANES),
    .LANE_MASK(LANE_MASK)
  ) i_bank (
    .rstN   (rstN),
    .strobe (strobe),
    .dataIn (dataIn),
    .dataOut(dataOut)
  );
endmodule

// File: rtl/ld_checker.sv
module ld_checker #(
  parameter int WIDTH     = 8,
  parameter int NUM_LANES = 2,
  parameter logic [NUM_LANES-1:0] LANE_MASK = 2'b01
) (
  input logic             sysClk,
  input logic             testClk,
  input logic             rstN,
  input logic             testMode,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] dataOut
);
  localparam int LANE_W = WIDTH / NUM_LANES;

  function automatic logic [WIDTH-1:0] delayedBits();
    logic [WIDTH-1:0] m;
    for (int b = 0; b < WIDTH; b++) m[b] = LANE_MASK[b / LANE_W];
    return m;
  endfunction

  localparam logic [WIDTH-1:0] DLY_BITS   = delayedBits();
  localparam logic [WIDTH-1:0] PLAIN_BITS = ~DLY_BITS;

  logic             armed;
  logic             modeAtEdge;
  logic [WIDTH-1:0] dataAtEdge;
  logic [WIDTH-1:0] outAtEdge;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      armed      <= 1'b0;
      modeAtEdge <= 1'b0;
      dataAtEdge <= '0;
      outAtEdge  <= '0;
    end else begin
      armed      <= 1'b1;
      modeAtEdge <= testMode;
      dataAtEdge <= dataIn;
      outAtEdge  <= dataOut;
    end
  end

  // R1: first edge after a clear still shows the cleared word
  p_reset_clear_r1: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(rstN) |-> dataOut == '0);

  // R2: after a normal-mode cycle the whole word equals the captured input
  p_normal_follow_r2: assert property (@(posedge sysClk) disable iff (!rstN)
    (armed && !modeAtEdge) |-> dataOut == dataAtEdge);

  // R4: delayed lanes unchanged from the clock edge up to the test clock rise
  p_hold_until_tclk_r4: assert property (@(posedge testClk) disable iff (!rstN)
    (armed && testMode && sysClk) |-> (dataOut & DLY_BITS) == (outAtEdge & DLY_BITS));

  // R5: test clock must be low when the system clock rises in test mode
  p_tclk_low_at_edge_r5: assert property (@(posedge sysClk) disable iff (!rstN)
    testMode |-> !testClk);

  // R5, R7: by the end of the high phase every lane holds the value captured at the edge
  p_delivered_r5: assert property (@(negedge sysClk) disable iff (!rstN)
    armed |-> dataOut == dataAtEdge);

  // R6: plain lanes already carry the captured word at the next edge
  p_plain_lanes_r6: assert property (@(posedge sysClk) disable iff (!rstN)
    armed |-> (dataOut & PLAIN_BITS) == (dataAtEdge & PLAIN_BITS));
endmodule

bind launch_delay_reg ld_checker #(
  .WIDTH    (WIDTH),
  .NUM_LANES(NUM_LANES),
  .LANE_MASK(LANE_MASK)
) i_checker (.*);

// File: tb/test_launch_delay_reg.sv
`timescale 1ns/100ps
module test_launch_delay_reg;
  localparam logic [7:0] DLY   = 8'h0F;
  localparam logic [7:0] PLAIN = 8'hF0;

  typedef struct {
    logic [7:0] oldVal;
    logic [7:0] newVal;
    bit         tm;
    bit         jitter;
    int         off;
  } item_t;

  logic       sysClk = 1'b0;
  logic       testClk = 1'b1;
  logic       rstN = 1'b0;
  logic       testMode = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;

  int         checks = 0;
  int         errors = 0;
  logic [7:0] lastVal = '0;
  item_t      sb[$];

  launch_delay_reg i_launch_delay_reg (
    .sysClk  (sysClk),
    .testClk (testClk),
    .rstN    (rstN),
    .testMode(testMode),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  always #4 sysClk = ~sysClk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %h expected %h", req, $time, act, exp);
    end
  endtask

  // Driver: one call per sysClk cycle.
  task automatic drive(input logic [7:0] val, input bit tm, input int off, input bit jitter);
    item_t it;
    @(negedge sysClk);
    #1;
    dataIn   = val;
    testMode = tm;
    testClk  = (tm || jitter) ? 1'b0 : 1'b1;
    it.oldVal = lastVal; it.newVal = val; it.tm = tm; it.jitter = jitter; it.off = off;
    sb.push_back(it);
    lastVal = val;
    @(posedge sysClk);
    #0.3;
    dataIn = ~val;              // R7: change while master holds
    if (tm || jitter) begin
      #(off - 0.3);
      testClk = 1'b1;
      #(3.7 - off);
      testClk = 1'b0;
    end
  endtask

  // Monitor: pops one expectation per sysClk rise.
  initial begin
    forever begin
      item_t it;
      @(posedge sysClk);
      if (sb.size() != 0) begin
        it = sb.pop_front();
        #0.5;
        if (it.tm) begin
          check("R6", dataOut & PLAIN, it.newVal & PLAIN);
          check("R4", dataOut & DLY, it.oldVal & DLY);
          #(it.off - 1.0);
          check("R4", dataOut & DLY, it.oldVal & DLY);
          #1;
          check("R5 R7", dataOut, it.newVal);
        end else begin
          check(it.jitter ? "R3" : "R2", dataOut, it.newVal);
          #3;
          check("R2 R7", dataOut, it.newVal);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge sysClk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2;
    check("R1", dataOut, 8'h00);
    @(negedge sysClk); #1;
    rstN = 1'b1;
    // R2: plain flip-flop behaviour
    for (int i = 0; i < 10; i++) drive(8'(i * 37 + 5), 1'b0, 1, 1'b0);
    // R3: test clock toggling without test mode
    for (int i = 0; i < 6; i++) drive(8'(i * 91 + 17), 1'b0, 1 + i % 3, 1'b1);
    // R4 R5 R6: delayed launch at several offsets
    for (int i = 0; i < 12; i++) drive(8'(i * 59 + 3), 1'b1, 1 + i % 3, 1'b0);
    drive(8'hA5, 1'b0, 1, 1'b0);
    drive(8'h5A, 1'b1, 2, 1'b0);
    drive(8'hFF, 1'b1, 3, 1'b0);
    // R1: mid-run clear
    while (sb.size() != 0) @(posedge sysClk);
    @(negedge sysClk); #1;
    rstN = 1'b0;
    #0.5;
    check("R1", dataOut, 8'h00);
    #1;
    rstN = 1'b1;
    lastVal = '0;
    for (int i = 0; i < 4; i++) drive(8'(i * 113 + 66), 1'b1, 3 - i % 3, 1'b0);
    for (int i = 0; i < 4; i++) drive(8'(i * 29 + 200), 1'b0, 1, 1'b0);
    while (sb.size() != 0) @(posedge sysClk);
    repeat (2) @(posedge sysClk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule